// File: doc/BRIEF.md
# Register-mapped SPI master

This block is a single-byte SPI master on a simple memory-mapped bus. Software sees two 32-bit registers. The control/status word holds several fields: the chip-select levels, a loopback switch, a 5-bit clock divider and a start bit. When the control word is read, the start bit reports busy. The data word holds the byte to send before a transfer and the byte received after it.

A transfer runs in a fixed order. Software writes the outgoing byte to the data word. It then writes the control word with the start bit set, polls until busy reads 0, and reads the received byte from the data word. The serial clock runs at the reference clock divided by 2·(N+1), where N is the divider field. The link uses SPI mode 0, sending the most significant bit first. The chip-select outputs are ordinary register bits and are not tied to the transfer, so software controls framing across several bytes.

Top module: `spi_regmap_master`

## Requirements
- R1: After reset the control word reads 0x00000015, all three chip-select outputs are 1, the serial clock is 0 and busy (bit 1) is 0.
- R2: The control word is at byte offset 0x0 and the data word at 0x4. Writes to the data word keep bits 7:0. Reads of the data word return that byte with bits 31:8 equal to 0.
- R3: Writing the control word with bit 1 set while idle starts a one-byte transfer. Bit 1 then reads 1 for exactly 16·(N+1) reference cycles after the write, and then reads 0.
- R4: The serial clock idles low. During a transfer it makes exactly 8 pulses, with a period of 2·(N+1) reference cycles, where N is control bits 31:27.
- R5: Bits go out most significant first. MOSI changes only while the serial clock is low, and MISO is sampled on each rising serial-clock edge. When the transfer ends, the assembled byte replaces the data word.
- R6: With control bit 3 set, the transmitted bits are looped back as the received data, and MISO is ignored.
- R7: Chip-select output n follows control bit 2·n from the cycle after any control write, including writes made during a transfer. A transfer does not change the chip-select outputs.
- R8: While busy, the following writes are ignored: writes to the data word, to the divider field, to the loopback bit, and a second start.
- R9: Control reads return the divider at bits 31:27, loopback at bit 3, busy at bit 1 and chip select n at bit 2·n. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select levels, one per control bit 2·n |

## Verification
Some properties are checked on every cycle. These are: the serial clock stays low while idle, MOSI holds steady while the serial clock is high, a start is always followed by busy, the chip-select outputs track each control write, and the divider and data word stay frozen during a transfer. Other behaviour can only be shown by the bench scenarios. These are: the exact busy length and clock period for several divider values, the received byte from an external slave, the loopback result with a conflicting MISO byte, and the ignored writes, observed through readback after the transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int unsigned OFS_CTRL  = 0;
   localparam int unsigned OFS_DATA  = 4;
   localparam int unsigned BIT_START = 1;
   localparam int unsigned BIT_LOOP  = 3;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_DATA
   } reg_sel_e;

endpackage

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int NUM_CS  = 3,
   parameter int DIV_W   = 5,
   parameter int DIV_LSB = 27,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              busy,
   input  logic              done,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              start,
   output logic              loop,
   output logic [DIV_W-1:0]  div,
   output logic [DATA_W-1:0] tx_byte,
   output logic [NUM_CS-1:0] cs
);

   reg_sel_e          sel;
   logic              wr_ctrl, wr_data;
   logic [NUM_CS-1:0] cs_q, wr_cs;
   logic              loop_q;
   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] data_q;
   logic [31:0]       cs_spread, ctrl_view;
   logic              unused_wbits;

   assign unused_wbits = ^bus_wdata;

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
      else if (bus_addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
   end

   assign wr_ctrl = bus_en && bus_we && (sel == SEL_CTRL);
   assign wr_data = bus_en && bus_we && (sel == SEL_DATA);
   assign start   = wr_ctrl && bus_wdata[BIT_START] && !busy;

   // chip-select n sits on even control bit 2n
   for (genvar n = 0; n < NUM_CS; n++) begin : g_cs_pick
      assign wr_cs[n] = bus_wdata[2*n];
   end

   for (genvar b = 0; b < 32; b++) begin : g_cs_view
      if ((b % 2 == 0) && (b / 2 < NUM_CS)) begin : g_on
         assign cs_spread[b] = cs_q[b/2];
      end else begin : g_off
         assign cs_spread[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= '1;
         loop_q <= 1'b0;
         div_q  <= '0;
         data_q <= '0;
      end else begin
         if (wr_ctrl) begin
            cs_q <= wr_cs;
            if (!busy) begin
               loop_q <= bus_wdata[BIT_LOOP];
               div_q  <= bus_wdata[DIV_LSB +: DIV_W];
            end
         end
         if (done) begin
            data_q <= rx_byte;
         end else if (wr_data && !busy) begin
            data_q <= bus_wdata[DATA_W-1:0];
         end
      end
   end

   always_comb begin
      ctrl_view = cs_spread;
      ctrl_view[BIT_START] = busy;
      ctrl_view[BIT_LOOP]  = loop_q;
      ctrl_view[DIV_LSB +: DIV_W] = div_q;
   end

   always_comb begin
      case (sel)
         SEL_CTRL: bus_rdata = ctrl_view;
         SEL_DATA: bus_rdata = {{(32-DATA_W){1'b0}}, data_q};
         default:  bus_rdata = '0;
      endcase
   end

   assign cs      = cs_q;
   assign loop    = loop_q;
   assign div     = div_q;
   assign tx_byte = data_q;

   // R7: a control write lands on the chip-select outputs one cycle later
   p_cs_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (cs == $past(wr_cs)));

   // R8: divider and loopback frozen during a transfer
   p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(div) && $stable(loop)));

   // R8: data word frozen during a transfer
   p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(tx_byte));

endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: a half period never starts while idle
   p_tick_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx,
   input  logic              tick,
   input  logic              loop,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx,
   output logic              sclk,
   output logic              mosi
);

   localparam int EDGES = 2 * DATA_W;
   localparam int EW    = $clog2(EDGES);

   logic [DATA_W-1:0] sh_q, rx_q;
   logic [EW-1:0]     edge_q;
   logic              busy_q, sclk_q, last, in_bit;

   assign last   = (edge_q == EW'(EDGES - 1));
   assign mosi   = busy_q && sh_q[DATA_W-1];
   assign in_bit = loop ? mosi : miso;
   assign done   = busy_q && tick && sclk_q && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         sh_q   <= '0;
         rx_q   <= '0;
         edge_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
         sh_q   <= tx;
         edge_q <= '0;
      end else if (busy_q && tick) begin
         sclk_q <= !sclk_q;
         edge_q <= edge_q + 1'b1;
         if (!sclk_q) begin
            rx_q <= {rx_q[DATA_W-2:0], in_bit};
         end else begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            if (last) busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign sclk = sclk_q;
   assign rx   = rx_q;

   // R4: serial clock idles low
   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R5: MOSI steady while the serial clock is high
   p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi_regmap_master.sv
module spi_regmap_master #(
   parameter int NUM_CS  = 3,
   parameter int DIV_W   = 5,
   parameter int DIV_LSB = 27,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs
);

   if (NUM_CS < 1 || 2*NUM_CS - 1 >= DIV_LSB) begin : g_bad_cs
      $error("chip-select field collides with divider field");
   end
   if (DIV_W < 1 || DIV_LSB + DIV_W > 32) begin : g_bad_div
      $error("divider field does not fit in 32 bits");
   end
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_data
      $error("data width out of range");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address too narrow for both offsets");
   end

   logic              start, busy, done, loop, tick;
   logic [DIV_W-1:0]  div;
   logic [DATA_W-1:0] tx_byte, rx_byte;

   spim_regs #(
      .NUM_CS(NUM_CS), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .rx_byte(rx_byte), .start(start),
      .loop(loop), .div(div), .tx_byte(tx_byte), .cs(spi_cs)
   );

   spim_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
   );

   spim_shifter #(.DATA_W(DATA_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .start(start), .tx(tx_byte), .tick(tick),
      .loop(loop), .miso(spi_miso), .busy(busy), .done(done),
      .rx(rx_byte), .sclk(spi_sclk), .mosi(spi_mosi)
   );

   // R3: an accepted start always raises busy
   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

endmodule

// File: tb/spi_regmap_master_bench.sv
`timescale 1ns/1ps
module spi_regmap_master_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        spi_sclk, spi_mosi, spi_miso;
   logic [2:0]  spi_cs;

   logic [7:0]  slave_byte = 8'h00;
   logic [2:0]  rise_idx = 3'd0;
   logic [7:0]  mosi_seen = 8'h00;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [31:0] cs_sh = 32'h15;
   int          got_busy, got_period, got_rises;
   logic [31:0] got_rx;

   always #5 clk = ~clk;

   spi_regmap_master u_spi_regmap_master (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs(spi_cs)
   );

   // slave model: presents MSB first, advances after each rising edge
   assign spi_miso = slave_byte[3'd7 - rise_idx];
   always @(posedge spi_sclk) begin
      mosi_seen <= {mosi_seen[6:0], spi_mosi};
      rise_idx  <= rise_idx + 3'd1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0; bus_addr = 4'h0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = 4'h0;
   endtask

   task automatic run_xfer(input logic [7:0] tx, input int n, input bit lp, input logic [7:0] sb);
      int r1, r2;
      bit prev;
      slave_byte = sb;
      got_busy = 0; got_rises = 0; r1 = 0; r2 = 0; prev = 1'b0;
      bus_wr(4'h4, {24'h0, tx});
      bus_wr(4'h0, cs_sh | (32'(n) << 27) | (32'(lp) << 3) | 32'h2);
      for (int k = 1; k <= 20000; k++) begin
         @(negedge clk);
         if (!bus_rdata[1]) break;
         got_busy++;
         if (spi_sclk && !prev) begin
            got_rises++;
            if (got_rises == 1) r1 = k;
            if (got_rises == 2) r2 = k;
         end
         prev = spi_sclk;
      end
      got_period = r2 - r1;
      bus_rd(4'h4, got_rx);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      bus_rd(4'h0, v);
      chk("R1 control reset value", v, 32'h15);
      chk("R1 chip selects high", {29'h0, spi_cs}, 32'h7);
      chk("R1 sclk idle low", {31'h0, spi_sclk}, 32'h0);
      bus_rd(4'h4, v);
      chk("R2 data reset value", v, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      bus_wr(4'h4, 32'hFFFF_FF5A);
      bus_rd(4'h4, v);
      chk("R2 data word zero-extended", v, 32'h5A);
      bus_wr(4'h0, 32'h8800_001D);
      bus_rd(4'h0, v);
      chk("R9 control field readback", v, 32'h8800_001D);
      bus_wr(4'h0, 32'h15);
   endtask

   task automatic t_divider();
      int      ns [4]  = '{0, 1, 4, 31};
      logic [7:0] txs [4] = '{8'hA5, 8'h01, 8'h80, 8'h6E};
      logic [7:0] sbs [4] = '{8'h3C, 8'hFE, 8'h7F, 8'hB1};
      logic [31:0] v;
      for (int i = 0; i < 4; i++) begin
         run_xfer(txs[i], ns[i], 1'b0, sbs[i]);
         chk("R3 busy length", 32'(got_busy), 32'(16 * (ns[i] + 1)));
         chk("R4 sclk period", 32'(got_period), 32'(2 * (ns[i] + 1)));
         chk("R4 sclk pulse count", 32'(got_rises), 32'd8);
         chk("R5 mosi bit order", {24'h0, mosi_seen}, {24'h0, txs[i]});
         chk("R5 received byte", got_rx, {24'h0, sbs[i]});
         bus_rd(4'h0, v);
         chk("R9 divider readback", v, cs_sh | (32'(ns[i]) << 27));
      end
   endtask

   task automatic t_loop();
      run_xfer(8'hC3, 2, 1'b1, 8'h3C);
      chk("R6 loopback returns tx byte", got_rx, 32'hC3);
      chk("R6 loopback wire bits", {24'h0, mosi_seen}, 32'hC3);
   endtask

   task automatic t_cs();
      logic [31:0] pats [3] = '{32'h00, 32'h04, 32'h11};
      logic [2:0]  exps [3] = '{3'b000, 3'b010, 3'b101};
      for (int i = 0; i < 3; i++) begin
         cs_sh = pats[i];
         bus_wr(4'h0, cs_sh);
         @(negedge clk);
         chk("R7 chip selects follow bits", {29'h0, spi_cs}, {29'h0, exps[i]});
      end
      run_xfer(8'h55, 0, 1'b0, 8'h0F);
      chk("R7 transfer leaves chip selects", {29'h0, spi_cs}, 32'h5);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      slave_byte = 8'h5A;
      cs_sh = 32'h15;
      bus_wr(4'h4, 32'h96);
      bus_wr(4'h0, 32'h15 | (32'd3 << 27) | 32'h2);
      bus_wr(4'h4, 32'hAA);
      bus_wr(4'h0, 32'h04 | (32'd9 << 27) | 32'h8 | 32'h2);
      @(negedge clk);
      chk("R7 chip select write while busy", {29'h0, spi_cs}, 32'h2);
      chk("R3 still busy mid-transfer", {31'h0, bus_rdata[1]}, 32'h1);
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (!bus_rdata[1]) break;
      end
      bus_rd(4'h0, v);
      chk("R8 divider and loop writes ignored", v, 32'h04 | (32'd3 << 27));
      bus_rd(4'h4, v);
      chk("R8 data write ignored, rx kept", v, 32'h5A);
      chk("R8 wire carried original byte", {24'h0, mosi_seen}, 32'h96);
      repeat (4) @(negedge clk);
      chk("R8 second start ignored", {31'h0, bus_rdata[1]}, 32'h0);
      cs_sh = 32'h04;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regs();
      t_divider();
      t_loop();
      t_cs();
      t_busy_ignore();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule